// File: doc/BRIEF.md
# Interrupt Vector Receive Mailbox

This block is a single-entry mailbox that sits between a system bus and a processor core. A sender delivers an interrupt packet as a burst of data beats on a valid/ready input. If the mailbox is free, it stores each beat in its own payload word and answers the sender with an acknowledge. It then sets its occupied flag, and the core sees a vector-trap request for as long as the flag stays set. If the mailbox is already occupied, it still takes the beats, but it throws them away, answers with a refusal and leaves the stored payload alone.

Software talks to the block through a small register port. Reading the status offset gives the occupied flag. Reading the three payload offsets gives the stored words. No read changes any state. Writing the value zero to the status offset empties the mailbox and drops the trap request. Writing any other value there does nothing.

The receive engine is a four-state machine. The states are RX_IDLE, RX_CAPTURE, RX_DISCARD and RX_RESPOND. Its transitions are:
- take-free: RX_IDLE to RX_CAPTURE, when the first beat arrives while the mailbox is empty.
- take-busy: RX_IDLE to RX_DISCARD, when the first beat arrives while the mailbox is occupied.
- capture-last: RX_CAPTURE to RX_RESPOND, on the final beat.
- discard-last: RX_DISCARD to RX_RESPOND, on the final beat.
- answer: RX_RESPOND to RX_IDLE, after one cycle.

While a packet is partway through, the machine stays in RX_CAPTURE or RX_DISCARD.

Top module: `ivr_top`

## Requirements
- R1: After reset the occupied flag is clear, `vec_trap` is 0, `rsp_valid` is 0 and `pkt_ready` is 1.
- R2: A packet is exactly three beats, each transferred on a cycle with `pkt_valid` and `pkt_ready` both high. In the cycle after the third beat, `rsp_valid` is high for exactly one cycle and `pkt_ready` is low in that cycle.
- R3: A packet whose first beat arrives while the mailbox is empty is answered with `rsp_ack`=1. Its beats 0, 1 and 2 can then be read at offsets 0x40, 0x50 and 0x60.
- R4: The occupied flag is set by the third beat of an accepted packet. `vec_trap` equals the flag, so it rises in the same cycle as the acknowledge and stays high until it is cleared.
- R5: A read with `reg_we`=0 gives `rd_valid`=1 in the next cycle. The status offset 0x00 returns the occupied flag in bit 0 and zero in every other bit. Reads change no state and do not clear the flag.
- R6: A packet whose first beat arrives while the mailbox is occupied is answered with `rsp_ack`=0. The stored words and the flag stay unchanged.
- R7: Writing a non-zero value to offset 0x00 is ignored. The flag and `vec_trap` stay high.
- R8: Writing zero to offset 0x00 clears the flag. `vec_trap` is 0 from the cycle after that write.
- R9: A read of any offset other than 0x00, 0x40, 0x50 or 0x60 returns zero with `rd_err`=1. Mapped reads return `rd_err`=0.
- R10: A write to any offset other than 0x00 has no effect, and no write produces `rd_valid`.
- R11: After the flag has been cleared, the next packet is accepted and replaces the stored payload.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| pkt_valid | input | 1 | Packet beat valid |
| pkt_data | input | 64 | Packet beat payload |
| pkt_ready | output | 1 | Beat can be taken |
| rsp_valid | output | 1 | One-cycle answer to the sender |
| rsp_ack | output | 1 | 1 = accepted, 0 = refused |
| reg_req | input | 1 | Register access request |
| reg_we | input | 1 | 1 = write, 0 = read |
| reg_addr | input | 8 | Register byte offset |
| reg_wdata | input | 64 | Write data |
| rd_valid | output | 1 | Read result valid |
| rd_data | output | 64 | Read result |
| rd_err | output | 1 | Read hit an unmapped offset |
| vec_trap | output | 1 | Interrupt-vector trap request to the core |

## Verification
Some faults in the machine's state would leave the flag set wrongly, for example a missed set or a spurious clear. These show on `vec_trap` and on the next status read within one cycle. A machine that picks the wrong path at the first beat shows up as a wrong `rsp_ack`, two cycles after the last beat at most. A payload word written on a refused packet, or stored at the wrong beat index, stays hidden until software reads that offset. For that reason the bench reads every word back after every accepted packet and after every refused one.

// File: rtl/ivr_pkg.sv
package ivr_pkg;
    typedef enum logic [1:0] {
        RX_IDLE,
        RX_CAPTURE,
        RX_DISCARD,
        RX_RESPOND
    } rx_state_e;

    localparam int STATUS_OFS  = 'h00;
    localparam int WORD_BASE   = 'h40;
    localparam int WORD_STRIDE = 'h10;
endpackage

// File: rtl/ivr_rx_fsm.sv
module ivr_rx_fsm
    import ivr_pkg::*;
#(
    parameter int NUM_WORDS = 3
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 pkt_valid,
    input  logic                 busy,
    output logic                 pkt_ready,
    output logic                 rsp_valid,
    output logic                 rsp_ack,
    output logic [NUM_WORDS-1:0] cap_we,
    output logic                 set_busy
);
    localparam int BEAT_W = (NUM_WORDS > 1) ? $clog2(NUM_WORDS) : 1;
    localparam logic [BEAT_W-1:0] LAST_BEAT = BEAT_W'(NUM_WORDS - 1);

    rx_state_e         state_q, state_d;
    logic [BEAT_W-1:0] beat_q, beat_d;
    logic              ack_q, ack_d;
    logic              fire;
    logic [BEAT_W-1:0] beat_idx;

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= RX_IDLE;
            beat_q  <= '0;
            ack_q   <= 1'b0;
        end else begin
            state_q <= state_d;
            beat_q  <= beat_d;
            ack_q   <= ack_d;
        end
    end

    assign fire     = pkt_valid && pkt_ready;
    assign beat_idx = (state_q == RX_IDLE) ? '0 : beat_q;

    // next-state logic
    always_comb begin
        state_d = state_q;
        beat_d  = beat_q;
        ack_d   = ack_q;
        unique case (state_q)
            RX_IDLE: begin
                if (fire) begin
                    beat_d  = BEAT_W'(1);
                    state_d = busy ? RX_DISCARD : RX_CAPTURE;
                end
            end
            RX_CAPTURE, RX_DISCARD: begin
                if (fire) begin
                    if (beat_q == LAST_BEAT) begin
                        state_d = RX_RESPOND;
                        ack_d   = (state_q == RX_CAPTURE);
                        beat_d  = '0;
                    end else begin
                        beat_d = beat_q + BEAT_W'(1);
                    end
                end
            end
            RX_RESPOND: begin
                state_d = RX_IDLE;
            end
            default: state_d = RX_IDLE;
        endcase
    end

    // output logic
    always_comb begin
        pkt_ready = 1'b1;
        rsp_valid = 1'b0;
        rsp_ack   = 1'b0;
        set_busy  = 1'b0;
        cap_we    = '0;
        unique case (state_q)
            RX_IDLE: begin
                if (fire && !busy) cap_we[0] = 1'b1;
            end
            RX_CAPTURE: begin
                for (int i = 0; i < NUM_WORDS; i++) begin
                    if (fire && beat_idx == BEAT_W'(i)) cap_we[i] = 1'b1;
                end
                set_busy = fire && (beat_q == LAST_BEAT);
            end
            RX_DISCARD: begin
                cap_we = '0;
            end
            RX_RESPOND: begin
                pkt_ready = 1'b0;
                rsp_valid = 1'b1;
                rsp_ack   = ack_q;
            end
            default: pkt_ready = 1'b1;
        endcase
    end
endmodule

// File: rtl/ivr_store.sv
module ivr_store #(
    parameter int NUM_WORDS = 3,
    parameter int DATA_W    = 64
) (
    input  logic                              clk,
    input  logic                              rst_n,
    input  logic [DATA_W-1:0]                 pkt_data,
    input  logic [NUM_WORDS-1:0]              cap_we,
    input  logic                              set_busy,
    input  logic                              clr_busy,
    output logic                              busy,
    output logic [NUM_WORDS-1:0][DATA_W-1:0]  words
);
    logic busy_q;

    always_ff @(posedge clk) begin
        if (!rst_n)        busy_q <= 1'b0;
        else if (set_busy) busy_q <= 1'b1;
        else if (clr_busy) busy_q <= 1'b0;
    end
    assign busy = busy_q;

    for (genvar g = 0; g < NUM_WORDS; g++) begin : g_word
        logic [DATA_W-1:0] word_q;
        always_ff @(posedge clk) begin
            if (!rst_n)        word_q <= '0;
            else if (cap_we[g]) word_q <= pkt_data;
        end
        assign words[g] = word_q;
    end
endmodule

// File: rtl/ivr_regport.sv
module ivr_regport
    import ivr_pkg::*;
#(
    parameter int NUM_WORDS = 3,
    parameter int DATA_W    = 64,
    parameter int ADDR_W    = 8
) (
    input  logic                              clk,
    input  logic                              rst_n,
    input  logic                              reg_req,
    input  logic                              reg_we,
    input  logic [ADDR_W-1:0]                 reg_addr,
    input  logic [DATA_W-1:0]                 reg_wdata,
    input  logic                              busy,
    input  logic [NUM_WORDS-1:0][DATA_W-1:0]  words,
    output logic                              clr_busy,
    output logic                              rd_valid,
    output logic [DATA_W-1:0]                 rd_data,
    output logic                              rd_err
);
    localparam logic [ADDR_W-1:0] STATUS_A = ADDR_W'(STATUS_OFS);

    logic [NUM_WORDS-1:0] word_hit;
    logic                 status_hit;
    logic                 any_hit;
    logic [DATA_W-1:0]    rd_mux;
    logic                 rd_stb;
    logic                 rd_valid_q, rd_err_q;
    logic [DATA_W-1:0]    rd_data_q;

    assign status_hit = (reg_addr == STATUS_A);

    for (genvar g = 0; g < NUM_WORDS; g++) begin : g_dec
        localparam logic [ADDR_W-1:0] WORD_A = ADDR_W'(WORD_BASE + g * WORD_STRIDE);
        assign word_hit[g] = (reg_addr == WORD_A);
    end

    assign any_hit  = status_hit || (|word_hit);
    assign rd_stb   = reg_req && !reg_we;
    assign clr_busy = reg_req && reg_we && status_hit && (reg_wdata == '0);

    always_comb begin
        rd_mux = '0;
        if (status_hit) rd_mux = {{(DATA_W-1){1'b0}}, busy};
        for (int i = 0; i < NUM_WORDS; i++) begin
            if (word_hit[i]) rd_mux = words[i];
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rd_valid_q <= 1'b0;
            rd_err_q   <= 1'b0;
            rd_data_q  <= '0;
        end else begin
            rd_valid_q <= rd_stb;
            rd_err_q   <= rd_stb && !any_hit;
            rd_data_q  <= rd_stb ? rd_mux : '0;
        end
    end

    assign rd_valid = rd_valid_q;
    assign rd_err   = rd_err_q;
    assign rd_data  = rd_data_q;
endmodule

// File: rtl/ivr_top.sv
module ivr_top #(
    parameter int NUM_WORDS = 3,
    parameter int DATA_W    = 64,
    parameter int ADDR_W    = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              pkt_valid,
    input  logic [DATA_W-1:0] pkt_data,
    output logic              pkt_ready,
    output logic              rsp_valid,
    output logic              rsp_ack,
    input  logic              reg_req,
    input  logic              reg_we,
    input  logic [ADDR_W-1:0] reg_addr,
    input  logic [DATA_W-1:0] reg_wdata,
    output logic              rd_valid,
    output logic [DATA_W-1:0] rd_data,
    output logic              rd_err,
    output logic              vec_trap
);
    logic                             busy;
    logic                             set_busy;
    logic                             clr_busy;
    logic [NUM_WORDS-1:0]             cap_we;
    logic [NUM_WORDS-1:0][DATA_W-1:0] words;

    ivr_rx_fsm #(.NUM_WORDS(NUM_WORDS)) u_fsm (
        .clk       (clk),
        .rst_n     (rst_n),
        .pkt_valid (pkt_valid),
        .busy      (busy),
        .pkt_ready (pkt_ready),
        .rsp_valid (rsp_valid),
        .rsp_ack   (rsp_ack),
        .cap_we    (cap_we),
        .set_busy  (set_busy)
    );

    ivr_store #(.NUM_WORDS(NUM_WORDS), .DATA_W(DATA_W)) u_store (
        .clk      (clk),
        .rst_n    (rst_n),
        .pkt_data (pkt_data),
        .cap_we   (cap_we),
        .set_busy (set_busy),
        .clr_busy (clr_busy),
        .busy     (busy),
        .words    (words)
    );

    ivr_regport #(.NUM_WORDS(NUM_WORDS), .DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_port (
        .clk       (clk),
        .rst_n     (rst_n),
        .reg_req   (reg_req),
        .reg_we    (reg_we),
        .reg_addr  (reg_addr),
        .reg_wdata (reg_wdata),
        .busy      (busy),
        .words     (words),
        .clr_busy  (clr_busy),
        .rd_valid  (rd_valid),
        .rd_data   (rd_data),
        .rd_err    (rd_err)
    );

    assign vec_trap = busy;
endmodule

// File: rtl/ivr_chk.sv
module ivr_chk #(
    parameter int DATA_W = 64,
    parameter int ADDR_W = 8
) (
    input logic              clk,
    input logic              rst_n,
    input logic              pkt_ready,
    input logic              rsp_valid,
    input logic              rsp_ack,
    input logic              reg_req,
    input logic              reg_we,
    input logic [ADDR_W-1:0] reg_addr,
    input logic [DATA_W-1:0] reg_wdata,
    input logic              rd_valid,
    input logic [DATA_W-1:0] rd_data,
    input logic              rd_err,
    input logic              vec_trap
);
    logic wr_zero, wr_nonzero;
    assign wr_zero    = reg_req && reg_we && (reg_addr == '0) && (reg_wdata == '0);
    assign wr_nonzero = reg_req && reg_we && (reg_addr == '0) && (reg_wdata != '0);

    p_resp_pulse_r2: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |=> !rsp_valid);
    p_resp_stall_r2: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |-> !pkt_ready);
    p_trap_rise_r4: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(vec_trap) |-> (rsp_valid && rsp_ack));
    p_trap_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (vec_trap && !wr_zero) |=> vec_trap);
    p_read_resp_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_req && !reg_we) |=> rd_valid);
    p_nack_busy_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && !rsp_ack) |-> vec_trap);
    p_nonzero_ign_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_nonzero && vec_trap) |=> vec_trap);
    p_clear_r8: assert property (@(posedge clk) disable iff (!rst_n)
        wr_zero |=> !vec_trap);
    p_unmapped_zero_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_valid && rd_err) |-> (rd_data == '0));
    p_write_silent_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_req && reg_we) |=> !rd_valid);
endmodule

bind ivr_top ivr_chk #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .pkt_ready (pkt_ready),
    .rsp_valid (rsp_valid),
    .rsp_ack   (rsp_ack),
    .reg_req   (reg_req),
    .reg_we    (reg_we),
    .reg_addr  (reg_addr),
    .reg_wdata (reg_wdata),
    .rd_valid  (rd_valid),
    .rd_data   (rd_data),
    .rd_err    (rd_err),
    .vec_trap  (vec_trap)
);

// File: tb/ivr_top_tb_top.sv
`timescale 1ns/1ps
module ivr_top_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        pkt_valid = 1'b0;
    logic [63:0] pkt_data = '0;
    logic        pkt_ready, rsp_valid, rsp_ack;
    logic        reg_req = 1'b0, reg_we = 1'b0;
    logic [7:0]  reg_addr = '0;
    logic [63:0] reg_wdata = '0;
    logic        rd_valid, rd_err, vec_trap;
    logic [63:0] rd_data;

    int n_chk = 0;
    int n_bad = 0;
    bit done  = 1'b0;

    logic [63:0] q_data[$];
    logic        q_err[$];
    string       q_tag[$];

    always #2 clk = ~clk;

    ivr_top dut_i (
        .clk(clk), .rst_n(rst_n),
        .pkt_valid(pkt_valid), .pkt_data(pkt_data), .pkt_ready(pkt_ready),
        .rsp_valid(rsp_valid), .rsp_ack(rsp_ack),
        .reg_req(reg_req), .reg_we(reg_we), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
        .rd_valid(rd_valid), .rd_data(rd_data), .rd_err(rd_err),
        .vec_trap(vec_trap)
    );

    task automatic check(string tag, logic [63:0] act, logic [63:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // scoreboard monitor
    initial begin
        forever begin
            @(negedge clk);
            if (rd_valid === 1'b1) begin
                if (q_data.size() == 0) begin
                    check("R10 unexpected read response", 64'd1, 64'd0);
                end else begin
                    automatic logic [63:0] ed = q_data.pop_front();
                    automatic logic        ee = q_err.pop_front();
                    automatic string       et = q_tag.pop_front();
                    check({et, " data"}, rd_data, ed);
                    check({et, " err"}, {63'd0, rd_err}, {63'd0, ee});
                end
            end
        end
    end

    task automatic rd(logic [7:0] a, logic [63:0] exp, logic err, string tag);
        @(negedge clk);
        reg_req = 1'b1; reg_we = 1'b0; reg_addr = a;
        q_data.push_back(exp); q_err.push_back(err); q_tag.push_back(tag);
        @(posedge clk);
        @(negedge clk);
        reg_req = 1'b0;
    endtask

    task automatic wr(logic [7:0] a, logic [63:0] d);
        @(negedge clk);
        reg_req = 1'b1; reg_we = 1'b1; reg_addr = a; reg_wdata = d;
        @(posedge clk);
        @(negedge clk);
        reg_req = 1'b0; reg_we = 1'b0;
    endtask

    task automatic send(logic [63:0] w0, logic [63:0] w1, logic [63:0] w2,
                        logic exp_ack, string tag);
        logic [63:0] w [3];
        w[0] = w0; w[1] = w1; w[2] = w2;
        for (int i = 0; i < 3; i++) begin
            @(negedge clk);
            while (pkt_ready !== 1'b1) @(negedge clk);
            pkt_valid = 1'b1; pkt_data = w[i];
            @(posedge clk);
        end
        @(negedge clk);
        pkt_valid = 1'b0;
        check({tag, " R2 rsp_valid"}, {63'd0, rsp_valid}, 64'd1);
        check({tag, " R2 ready low"}, {63'd0, pkt_ready}, 64'd0);
        check({tag, " R3/R6 ack"}, {63'd0, rsp_ack}, {63'd0, exp_ack});
        @(negedge clk);
        check({tag, " R2 single pulse"}, {63'd0, rsp_valid}, 64'd0);
    endtask

    task automatic rd_words(logic [63:0] a, logic [63:0] b, logic [63:0] c, string tag);
        rd(8'h40, a, 1'b0, {tag, " word0"});
        rd(8'h50, b, 1'b0, {tag, " word1"});
        rd(8'h60, c, 1'b0, {tag, " word2"});
    endtask

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check("R1 trap reset", {63'd0, vec_trap}, 64'd0);
        check("R1 rsp reset", {63'd0, rsp_valid}, 64'd0);
        check("R1 ready reset", {63'd0, pkt_ready}, 64'd1);
        rd(8'h00, 64'd0, 1'b0, "R1 status reset");

        send(64'hA0A0_0000_1111_0001, 64'hA1A1_0000_2222_0002, 64'hA2A2_0000_3333_0003, 1'b1, "pktA");
        check("R4 trap after accept", {63'd0, vec_trap}, 64'd1);
        rd(8'h00, 64'd1, 1'b0, "R5 status busy");
        rd_words(64'hA0A0_0000_1111_0001, 64'hA1A1_0000_2222_0002, 64'hA2A2_0000_3333_0003, "R3 pktA");
        rd(8'h00, 64'd1, 1'b0, "R5 status after reads");

        send(64'hBBBB_0000_0000_0001, 64'hBBBB_0000_0000_0002, 64'hBBBB_0000_0000_0003, 1'b0, "pktB");
        rd_words(64'hA0A0_0000_1111_0001, 64'hA1A1_0000_2222_0002, 64'hA2A2_0000_3333_0003, "R6 kept");
        check("R6 trap stays", {63'd0, vec_trap}, 64'd1);

        wr(8'h00, 64'h0000_0000_0000_0100);
        check("R7 trap after nonzero write", {63'd0, vec_trap}, 64'd1);
        rd(8'h00, 64'd1, 1'b0, "R7 status after nonzero write");

        wr(8'h50, 64'hDEAD_BEEF_DEAD_BEEF);
        rd(8'h50, 64'hA1A1_0000_2222_0002, 1'b0, "R10 data write ignored");

        rd(8'h20, 64'd0, 1'b1, "R9 unmapped 0x20");
        rd(8'h44, 64'd0, 1'b1, "R9 unmapped 0x44");
        rd(8'hF0, 64'd0, 1'b1, "R9 unmapped 0xF0");

        wr(8'h00, 64'd0);
        check("R8 trap drops", {63'd0, vec_trap}, 64'd0);
        rd(8'h00, 64'd0, 1'b0, "R8 status cleared");

        send(64'hC0C0_C0C0_0000_0000, 64'hC1C1_C1C1_0000_0000, 64'hC2C2_C2C2_0000_0000, 1'b1, "pktC");
        check("R11 trap again", {63'd0, vec_trap}, 64'd1);
        rd_words(64'hC0C0_C0C0_0000_0000, 64'hC1C1_C1C1_0000_0000, 64'hC2C2_C2C2_0000_0000, "R11 pktC");

        wr(8'h00, 64'd0);
        send(64'd1, 64'd2, 64'd3, 1'b1, "pktD");
        send(64'd7, 64'd8, 64'd9, 1'b0, "pktE");
        rd_words(64'd1, 64'd2, 64'd3, "R6 pktD kept");

        repeat (4) @(negedge clk);
        check("scoreboard drained", 64'(q_data.size()), 64'd0);
        done = 1'b1;
        $display("test done: total=%0d bad=%0d", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog actual=running expected=finished");
            $display("test done: total=%0d bad=%0d", n_chk, n_bad);
            $finish;
        end
    end
endmodule